// File: doc/BRIEF.md
# Time-Bucketed Event Calendar Drain

This block holds far-future simulation events in a ring of small unordered buckets. Each bucket spans one fixed window of simulated time. An event arrives with a time tag, two bead identifiers and the time it was enqueued. The time tag picks a bucket, and the event is appended at the end of that bucket. Events are never removed one by one. To cancel events, a separate port records, for each bead, the time at which that bead was last invalidated.

When the downstream priority queue runs short of events, it pulses a drain request. The block then streams the bucket at the head of the ring through a staleness filter. An event survives only if it was enqueued strictly after the last invalidation of both of its beads. Surviving events go into an insertion-sort chain, one per cycle. The chain is then emitted in ascending time order on a valid/ready stream, closed by an end-of-bucket beat. After that beat the bucket is empty and the head moves to the next bucket.

Back-pressure rules:
- The output stream holds every field steady while `out_valid` is high and `out_ready` is low.
- A beat transfers on a clock edge where both are high.
- `ins_ready` is tied high, so an insert is taken on every cycle where `ins_valid` is high. A refused insert is reported through `ins_err` instead of by stalling.

Top module: `bucket_drain_calendar`

## Requirements
- R1: After reset, `drain_busy`, `out_valid` and `ins_err` are low. The head bucket is bucket 0, every bucket is empty, and every bead's last-invalidation time is 0.
- R2: An inserted event goes to bucket number (time tag >> SLOT_LOG) mod NUM_BUCKETS. Successive drains visit buckets 0, 1, 2, … and wrap around the ring.
- R3: A drain emits the surviving events of the head bucket in ascending time tag order. Events with equal tags leave in the order they were inserted.
- R4: An event is emitted only if its enqueue stamp is strictly greater than the last-invalidation time of bead A and of bead B. Any other event is dropped without any beat.
- R5: Every drain ends with exactly one beat carrying `out_eob`=1 and all data fields zero. This beat is the only beat when nothing survives. `drain_busy` is low in the cycle after that beat transfers, and the drained bucket is then empty.
- R6: While `out_valid` is high and `out_ready` is low, `out_valid` and every output field stay unchanged on the next cycle.
- R7: An insert whose bucket is the head bucket is rejected when `drain_busy` or `drain_req` is high in that cycle. The event is not stored, and `ins_err` is high for the following cycle. Inserts to other buckets are accepted during a drain.
- R8: An insert into a bucket that already holds BUCKET_DEPTH events is rejected in the same way.
- R9: A drain request while `drain_busy` is high is ignored. No second drain follows the current one.
- R10: An invalidation record written in one cycle applies to every event streamed from the next cycle on. This includes events stored before the record was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ins_valid | input | 1 | Insert request |
| ins_ready | output | 1 | Always high; inserts are never stalled |
| ins_tag | input | 16 | Event time tag |
| ins_bead_a | input | 4 | First bead of the event |
| ins_bead_b | input | 4 | Second bead of the event |
| ins_stamp | input | 16 | Time the event was enqueued |
| ins_err | output | 1 | Previous-cycle insert was rejected |
| inv_valid | input | 1 | Write an invalidation record |
| inv_bead | input | 4 | Bead being invalidated |
| inv_time | input | 16 | Invalidation time for that bead |
| drain_req | input | 1 | Start draining the head bucket |
| drain_busy | output | 1 | A drain is in progress |
| out_valid | output | 1 | Output beat present |
| out_ready | input | 1 | Consumer accepts the beat |
| out_tag | output | 16 | Time tag of emitted event |
| out_bead_a | output | 4 | First bead of emitted event |
| out_bead_b | output | 4 | Second bead of emitted event |
| out_stamp | output | 16 | Enqueue stamp of emitted event |
| out_eob | output | 1 | End-of-bucket beat |

## Verification
The assertions check the following on every cycle:
- No bucket or sort chain is overfilled.
- The head of the sort chain never holds a later tag than its successor.
- The output holds steady under back-pressure.
- `ins_err` only follows an insert.
- The end-of-bucket handshake returns the block to idle, and no beat appears while idle.

Only the bench scenarios can show the remaining behaviour:
- the mapping from time tag to bucket and the order in which buckets are visited;
- tie order among equal tags;
- which events the lazy staleness test drops, including the boundary where the stamp equals the invalidation time;
- that a rejected or ignored request leaves no trace in a later drain.

// File: rtl/dcal_pkg.sv
package dcal_pkg;
  localparam int TAG_W  = 16;
  localparam int BEAD_W = 4;

  typedef struct packed {
    logic [TAG_W-1:0]  tag;
    logic [BEAD_W-1:0] bead_a;
    logic [BEAD_W-1:0] bead_b;
    logic [TAG_W-1:0]  stamp;
  } dcal_event_t;
endpackage

// File: rtl/dcal_bucket_store.sv
module dcal_bucket_store
  import dcal_pkg::*;
#(
  parameter int NUM_BUCKETS  = 4,
  parameter int BUCKET_DEPTH = 8
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             wr_en,
  input  logic [$clog2(NUM_BUCKETS)-1:0]   wr_bkt,
  input  dcal_event_t                      wr_ev,
  output logic                             wr_full,
  input  logic [$clog2(NUM_BUCKETS)-1:0]   rd_bkt,
  input  logic [$clog2(BUCKET_DEPTH+1)-1:0] rd_idx,
  output dcal_event_t                      rd_ev,
  output logic [$clog2(BUCKET_DEPTH+1)-1:0] rd_cnt,
  input  logic                             clr_en
);
  localparam int CNT_W = $clog2(BUCKET_DEPTH + 1);
  localparam int ADR_W = $clog2(BUCKET_DEPTH);

  dcal_event_t      slots [NUM_BUCKETS][BUCKET_DEPTH];
  logic [CNT_W-1:0] fill  [NUM_BUCKETS];

  assign wr_full = (fill[wr_bkt] == CNT_W'(BUCKET_DEPTH));
  assign rd_ev   = slots[rd_bkt][rd_idx[ADR_W-1:0]];
  assign rd_cnt  = fill[rd_bkt];

  // Append-only storage: each bucket is an array written at its fill level.
  always_ff @(posedge clk) begin
    if (wr_en && !wr_full)
      slots[wr_bkt][fill[wr_bkt][ADR_W-1:0]] <= wr_ev;
  end

  for (genvar b = 0; b < NUM_BUCKETS; b++) begin : g_fill
    always_ff @(posedge clk) begin
      if (!rst_n)
        fill[b] <= '0;
      else if (clr_en && rd_bkt == b[$clog2(NUM_BUCKETS)-1:0])
        fill[b] <= '0;
      else if (wr_en && !wr_full && wr_bkt == b[$clog2(NUM_BUCKETS)-1:0])
        fill[b] <= fill[b] + CNT_W'(1);
    end

    p_fill_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
      fill[b] <= CNT_W'(BUCKET_DEPTH));
  end
endmodule

// File: rtl/dcal_stale_filter.sv
module dcal_stale_filter
  import dcal_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rec_valid,
  input  logic [BEAD_W-1:0] rec_bead,
  input  logic [TAG_W-1:0]  rec_time,
  input  dcal_event_t       ev,
  output logic              fresh
);
  localparam int NUM_BEADS = 1 << BEAD_W;

  logic [TAG_W-1:0] last_inv [NUM_BEADS];

  for (genvar i = 0; i < NUM_BEADS; i++) begin : g_inv
    always_ff @(posedge clk) begin
      if (!rst_n)
        last_inv[i] <= '0;
      else if (rec_valid && rec_bead == i[BEAD_W-1:0])
        last_inv[i] <= rec_time;
    end
  end

  // Lazy validity: the event must postdate the last invalidation of both beads.
  assign fresh = (ev.stamp > last_inv[ev.bead_a]) && (ev.stamp > last_inv[ev.bead_b]);
endmodule

// File: rtl/dcal_sort_chain.sv
module dcal_sort_chain
  import dcal_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        push,
  input  dcal_event_t push_ev,
  input  logic        pop,
  output dcal_event_t head_ev,
  output logic        empty
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  dcal_event_t      cells [DEPTH];
  dcal_event_t      cells_nx [DEPTH];
  logic [CNT_W-1:0] used, used_nx;

  assign head_ev = cells[0];
  assign empty   = (used == '0);

  // One insertion-sort step per push: find the slot after all entries with
  // a tag not later than the newcomer, shift the tail down by one.
  always_comb begin
    int pos;
    pos      = 0;
    cells_nx = cells;
    used_nx  = used;
    for (int k = 0; k < DEPTH; k++)
      if (k < int'(used) && cells[k].tag <= push_ev.tag) pos++;
    if (push) begin
      for (int k = 0; k < DEPTH; k++) begin
        if (k == pos)     cells_nx[k] = push_ev;
        else if (k > pos) cells_nx[k] = cells[(k > 0) ? k - 1 : 0];
      end
      used_nx = used + CNT_W'(1);
    end else if (pop) begin
      for (int k = 0; k < DEPTH - 1; k++) cells_nx[k] = cells[k + 1];
      cells_nx[DEPTH-1] = '0;
      used_nx = used - CNT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      used <= '0;
      for (int k = 0; k < DEPTH; k++) cells[k] <= '0;
    end else begin
      used <= used_nx;
      for (int k = 0; k < DEPTH; k++) cells[k] <= cells_nx[k];
    end
  end

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> used < CNT_W'(DEPTH));

  p_head_ordered_r3: assert property (@(posedge clk) disable iff (!rst_n)
    used >= CNT_W'(2) |-> cells[0].tag <= cells[1].tag);

  p_no_mixed_op_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(push && pop));
endmodule

// File: rtl/bucket_drain_calendar.sv
module bucket_drain_calendar
  import dcal_pkg::*;
#(
  parameter int NUM_BUCKETS  = 4,
  parameter int BUCKET_DEPTH = 8,
  parameter int SLOT_LOG     = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ins_valid,
  output logic              ins_ready,
  input  logic [TAG_W-1:0]  ins_tag,
  input  logic [BEAD_W-1:0] ins_bead_a,
  input  logic [BEAD_W-1:0] ins_bead_b,
  input  logic [TAG_W-1:0]  ins_stamp,
  output logic              ins_err,
  input  logic              inv_valid,
  input  logic [BEAD_W-1:0] inv_bead,
  input  logic [TAG_W-1:0]  inv_time,
  input  logic              drain_req,
  output logic              drain_busy,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [TAG_W-1:0]  out_tag,
  output logic [BEAD_W-1:0] out_bead_a,
  output logic [BEAD_W-1:0] out_bead_b,
  output logic [TAG_W-1:0]  out_stamp,
  output logic              out_eob
);
  localparam int BKT_W = $clog2(NUM_BUCKETS);
  localparam int CNT_W = $clog2(BUCKET_DEPTH + 1);

  typedef enum logic [1:0] {ST_IDLE, ST_LOAD, ST_EMIT} phase_t;

  phase_t           phase;
  logic [BKT_W-1:0] head;
  logic [CNT_W-1:0] rd_idx, head_cnt;
  dcal_event_t      ins_ev, rd_ev, chain_head, beat;
  logic [BKT_W-1:0] ins_bkt;
  logic             ins_full, ins_reject, ins_write;
  logic             loading, fresh, push, pop, finish, chain_empty;

  assign ins_ready  = 1'b1;
  assign ins_ev     = '{tag: ins_tag, bead_a: ins_bead_a, bead_b: ins_bead_b, stamp: ins_stamp};
  assign ins_bkt    = ins_tag[SLOT_LOG +: BKT_W];
  assign drain_busy = (phase != ST_IDLE);
  assign ins_reject = ins_full || ((drain_busy || drain_req) && ins_bkt == head);
  assign ins_write  = ins_valid && !ins_reject;

  assign loading = (phase == ST_LOAD) && (rd_idx < head_cnt);
  assign push    = loading && fresh;

  assign out_valid = (phase == ST_EMIT);
  assign out_eob   = out_valid && chain_empty;
  assign beat      = (out_valid && !chain_empty) ? chain_head : '0;
  assign out_tag    = beat.tag;
  assign out_bead_a = beat.bead_a;
  assign out_bead_b = beat.bead_b;
  assign out_stamp  = beat.stamp;
  assign pop    = out_valid && out_ready && !chain_empty;
  assign finish = out_valid && out_ready && chain_empty;

  dcal_bucket_store #(.NUM_BUCKETS(NUM_BUCKETS), .BUCKET_DEPTH(BUCKET_DEPTH)) i_store (
    .clk(clk), .rst_n(rst_n),
    .wr_en(ins_write), .wr_bkt(ins_bkt), .wr_ev(ins_ev), .wr_full(ins_full),
    .rd_bkt(head), .rd_idx(rd_idx), .rd_ev(rd_ev), .rd_cnt(head_cnt),
    .clr_en(finish)
  );

  dcal_stale_filter i_filter (
    .clk(clk), .rst_n(rst_n),
    .rec_valid(inv_valid), .rec_bead(inv_bead), .rec_time(inv_time),
    .ev(rd_ev), .fresh(fresh)
  );

  dcal_sort_chain #(.DEPTH(BUCKET_DEPTH)) i_chain (
    .clk(clk), .rst_n(rst_n),
    .push(push), .push_ev(rd_ev), .pop(pop),
    .head_ev(chain_head), .empty(chain_empty)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase  <= ST_IDLE;
      head   <= '0;
      rd_idx <= '0;
    end else begin
      unique case (phase)
        ST_IDLE: if (drain_req) begin
          phase  <= ST_LOAD;
          rd_idx <= '0;
        end
        ST_LOAD: begin
          if (loading) rd_idx <= rd_idx + CNT_W'(1);
          else         phase  <= ST_EMIT;
        end
        ST_EMIT: if (finish) begin
          phase <= ST_IDLE;
          head  <= head + BKT_W'(1);
        end
        default: phase <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ins_err <= 1'b0;
    else        ins_err <= ins_valid && ins_reject;
  end

  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_tag) && $stable(out_bead_a)
      && $stable(out_bead_b) && $stable(out_stamp) && $stable(out_eob));

  p_err_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ins_err |-> $past(ins_valid));

  p_eob_ends_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && out_eob |=> !drain_busy);

  p_idle_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !drain_busy |-> !out_valid);
endmodule

// File: tb/test_bucket_drain_calendar.sv
module test_bucket_drain_calendar;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ins_valid = 1'b0, ins_ready, ins_err;
  logic [15:0] ins_tag = '0, ins_stamp = '0;
  logic [3:0]  ins_bead_a = '0, ins_bead_b = '0;
  logic        inv_valid = 1'b0;
  logic [3:0]  inv_bead = '0;
  logic [15:0] inv_time = '0;
  logic        drain_req = 1'b0, drain_busy;
  logic        out_valid, out_ready = 1'b0, out_eob;
  logic [15:0] out_tag, out_stamp;
  logic [3:0]  out_bead_a, out_bead_b;

  int total = 0;
  int bad = 0;
  logic [15:0] exp_tag [16];
  logic [3:0]  exp_bead [16];
  int          exp_n;

  always #5 clk = ~clk;

  bucket_drain_calendar i_bucket_drain_calendar (
    .clk(clk), .rst_n(rst_n),
    .ins_valid(ins_valid), .ins_ready(ins_ready), .ins_tag(ins_tag),
    .ins_bead_a(ins_bead_a), .ins_bead_b(ins_bead_b), .ins_stamp(ins_stamp), .ins_err(ins_err),
    .inv_valid(inv_valid), .inv_bead(inv_bead), .inv_time(inv_time),
    .drain_req(drain_req), .drain_busy(drain_busy),
    .out_valid(out_valid), .out_ready(out_ready), .out_tag(out_tag),
    .out_bead_a(out_bead_a), .out_bead_b(out_bead_b), .out_stamp(out_stamp), .out_eob(out_eob)
  );

  task automatic check(input logic ok, input string req, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic put(input logic [15:0] tag, input logic [3:0] a, input logic [3:0] b,
                     input logic [15:0] stamp, input logic want_err, input string req);
    @(negedge clk);
    ins_valid = 1'b1; ins_tag = tag; ins_bead_a = a; ins_bead_b = b; ins_stamp = stamp;
    @(negedge clk);
    ins_valid = 1'b0;
    check(ins_err == want_err, req, int'(ins_err), int'(want_err));
  endtask

  task automatic record_inv(input logic [3:0] bead, input logic [15:0] t);
    @(negedge clk);
    inv_valid = 1'b1; inv_bead = bead; inv_time = t;
    @(negedge clk);
    inv_valid = 1'b0;
  endtask

  task automatic start_drain();
    @(negedge clk);
    drain_req = 1'b1;
    @(negedge clk);
    drain_req = 1'b0;
  endtask

  // Collects beats up to the end-of-bucket beat; stall inserts ready-low cycles.
  task automatic collect(input bit stall, input string req);
    int idx = 0;
    bit seen_eob = 0;
    bit held = 0;
    logic [15:0] held_tag = '0;
    for (int cyc = 0; cyc < 200 && !seen_eob; cyc++) begin
      if (held) begin
        check(out_valid && out_tag == held_tag, "R6", int'(out_tag), int'(held_tag));
        held = 0;
      end
      out_ready = stall ? (cyc % 3 == 2) : 1'b1;
      if (out_valid && !out_ready) begin
        held = 1;
        held_tag = out_tag;
      end
      if (out_valid && out_ready) begin
        if (out_eob) begin
          seen_eob = 1;
          check(out_tag == 0 && out_stamp == 0, "R5", int'(out_tag), 0);
        end else begin
          if (idx < exp_n)
            check(out_tag == exp_tag[idx] && out_bead_a == exp_bead[idx], req,
                  int'(out_tag), int'(exp_tag[idx]));
          else
            check(1'b0, req, int'(out_tag), -1);
          idx++;
        end
      end
      @(negedge clk);
    end
    out_ready = 1'b0;
    check(seen_eob, "R5", int'(seen_eob), 1);
    check(idx == exp_n, req, idx, exp_n);
    check(!drain_busy, "R5", int'(drain_busy), 0);
  endtask

  task automatic t_reset();
    check(!drain_busy && !out_valid && !ins_err, "R1", int'({drain_busy, out_valid, ins_err}), 0);
  endtask

  task automatic t_sort();
    put(16'd10, 4'd9,  4'd0, 16'd1, 1'b0, "R2");
    put(16'd3,  4'd10, 4'd0, 16'd1, 1'b0, "R2");
    put(16'd7,  4'd11, 4'd0, 16'd1, 1'b0, "R2");
    put(16'd3,  4'd12, 4'd0, 16'd1, 1'b0, "R2");
    put(16'd15, 4'd13, 4'd0, 16'd1, 1'b0, "R2");
    exp_n = 5;
    exp_tag[0] = 3;  exp_bead[0] = 10;
    exp_tag[1] = 3;  exp_bead[1] = 12;
    exp_tag[2] = 7;  exp_bead[2] = 11;
    exp_tag[3] = 10; exp_bead[3] = 9;
    exp_tag[4] = 15; exp_bead[4] = 13;
    start_drain();
    collect(0, "R3");
  endtask

  task automatic t_map();
    put(16'd20, 4'd9, 4'd0, 16'd1, 1'b0, "R2");
    put(16'd36, 4'd9, 4'd0, 16'd1, 1'b0, "R2");
    put(16'd68, 4'd9, 4'd0, 16'd1, 1'b0, "R2");
    exp_n = 1; exp_tag[0] = 20; exp_bead[0] = 9;
    start_drain(); collect(0, "R2");
    exp_n = 1; exp_tag[0] = 36;
    start_drain(); collect(0, "R2");
    exp_n = 0;
    start_drain(); collect(0, "R2");
    exp_n = 1; exp_tag[0] = 68;
    start_drain(); collect(0, "R2");
  endtask

  task automatic t_stale();
    put(16'd17, 4'd1, 4'd2, 16'd5, 1'b0, "R4");
    put(16'd18, 4'd3, 4'd4, 16'd5, 1'b0, "R4");
    put(16'd19, 4'd5, 4'd6, 16'd5, 1'b0, "R4");
    put(16'd21, 4'd7, 4'd8, 16'd9, 1'b0, "R4");
    record_inv(4'd3, 16'd8);
    record_inv(4'd6, 16'd2);
    record_inv(4'd7, 16'd9);
    exp_n = 2;
    exp_tag[0] = 17; exp_bead[0] = 1;
    exp_tag[1] = 19; exp_bead[1] = 5;
    start_drain();
    collect(0, "R10");
  endtask

  task automatic t_backpressure();
    put(16'd40, 4'd9,  4'd0, 16'd1, 1'b0, "R2");
    put(16'd33, 4'd10, 4'd0, 16'd1, 1'b0, "R2");
    exp_n = 2;
    exp_tag[0] = 33; exp_bead[0] = 10;
    exp_tag[1] = 40; exp_bead[1] = 9;
    start_drain();
    collect(1, "R6");
  endtask

  task automatic t_reject();
    put(16'd50, 4'd9, 4'd0, 16'd1, 1'b0, "R7");
    start_drain();
    put(16'd49, 4'd10, 4'd0, 16'd1, 1'b1, "R7");
    put(16'd86, 4'd11, 4'd0, 16'd1, 1'b0, "R7");
    start_drain();
    exp_n = 1; exp_tag[0] = 50; exp_bead[0] = 9;
    collect(0, "R7");
    repeat (3) @(negedge clk);
    check(!drain_busy && !out_valid, "R9", int'(drain_busy), 0);
  endtask

  task automatic t_full();
    for (int k = 0; k < 8; k++)
      put(16'(7 - k), 4'(8 + k), 4'd0, 16'd1, 1'b0, "R8");
    put(16'd8, 4'd9, 4'd0, 16'd1, 1'b1, "R8");
    exp_n = 8;
    for (int k = 0; k < 8; k++) begin
      exp_tag[k]  = 16'(k);
      exp_bead[k] = 4'(15 - k);
    end
    start_drain();
    collect(0, "R8");
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 100000, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_sort();
    t_map();
    t_stale();
    t_backpressure();
    t_reject();
    t_full();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule